// File: doc/BRIEF.md
# SDRAM Burst Column Address Sequencer

This block produces the column address for every beat of a synchronous DRAM read or write burst. A controller pulses `start_i` together with the first column, a burst-length code and an ordering bit. From the next clock on, the block presents one column per cycle on `col_o` until the burst is complete. `last_o` marks the final beat, and `done_o` pulses once after the burst has ended.

Columns are generated in one of two orders. Sequential order counts up and wraps inside the aligned block that the burst length defines. Interleaved order XORs the low bits of the start column with the beat index. A full-page burst (sequential only) walks every column and wraps from the top back to zero. It only stops on `term_i` or on a new start. A new start is accepted on any cycle and replaces the running burst at once. Illegal setups are flagged and shortened to a single beat.

Top module: `sdram_burst_colseq`

## Requirements
- R1: After reset, `active_o`, `last_o`, `done_o` and `illegal_o` are 0 and `col_o` is 0.
- R2: The burst-length code maps 0, 1, 2 and 3 to 1, 2, 4 and 8 beats, and code 7 to a full-page burst. Codes 4, 5 and 6 are reserved: they set `illegal_o` and give a 1-beat burst.
- R3: When `start_i` is sampled high on a rising edge, the next cycle shows `active_o`=1 and `col_o` equal to the sampled start column (beat 0).
- R4: In sequential order with burst length BL, beat k shows the start column with its low log2(BL) bits replaced by (start + k) mod BL. The upper bits stay unchanged.
- R5: In interleaved order with burst length BL, beat k shows the start column with its low log2(BL) bits XORed with k.
- R6: A full-page burst advances the 9-bit column by one each cycle, wrapping from 511 to 0. It never asserts `last_o` and runs until it is terminated or replaced.
- R7: `last_o` is high exactly on beat BL-1 of a finite burst. On the following cycle `active_o` is 0 and `done_o` is 1 for one cycle. A 1-beat burst shows only the start column.
- R8: `term_i` sampled high during a burst, with `start_i` low, makes the beat then shown the final one. The next cycle has `active_o`=0 and `done_o`=1.
- R9: `start_i` sampled during a burst replaces it in the next cycle with beat 0 of the new burst, with no `done_o` pulse. `start_i` takes precedence over a simultaneous `term_i`.
- R10: A full-page code (7) with interleaved order sets `illegal_o` and runs as a 1-beat burst. `illegal_o` stays valid for the whole burst and is cleared by the next legal start.
- R11: `term_i` while no burst is active has no effect: `done_o` and `active_o` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a new burst (replaces any running burst) |
| term_i | input | 1 | End the running burst |
| col_start_i | input | 9 | First column of the burst |
| blen_code_i | input | 3 | Burst-length code (see R2) |
| interleave_i | input | 1 | 1 = interleaved order, 0 = sequential |
| col_o | output | 9 | Column for the current beat |
| active_o | output | 1 | A beat is being presented |
| last_o | output | 1 | Current beat is the last of a finite burst |
| done_o | output | 1 | One-cycle pulse after a burst ends |
| illegal_o | output | 1 | Current burst was requested with an illegal setup |

## Verification
Sequential bursts of 4 and 8 beats are started at unaligned columns, so that wrap inside the aligned block is told apart from plain counting across it. An interleaved 8-beat burst from the same kind of column separates XOR ordering from both. A full-page burst started near column 511 shows the wrap to 0, the absence of `last_o`, and a mid-burst terminate. A restart that coincides with a terminate checks both replacement and precedence. The illegal codes and a terminate while idle cover the degenerate cases.

// File: rtl/sdram_burst_colseq.sv
module sdram_burst_colseq #(
  parameter int COL_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             term_i,
  input  logic [COL_W-1:0] col_start_i,
  input  logic [2:0]       blen_code_i,
  input  logic             interleave_i,
  output logic [COL_W-1:0] col_o,
  output logic             active_o,
  output logic             last_o,
  output logic             done_o,
  output logic             illegal_o
);

  localparam logic [2:0] FULL_CODE = 3'd7;

  logic [COL_W-1:0] base_q, beat_q, mask_q;
  logic             full_q, inter_q, active_q, done_q, illegal_q;

  logic [COL_W-1:0] mask_d;
  logic             full_d, illegal_d;

  always_comb begin
    mask_d    = '0;
    full_d    = 1'b0;
    illegal_d = 1'b0;
    case (blen_code_i)
      3'd0, 3'd1, 3'd2, 3'd3:
        mask_d = COL_W'((1 << blen_code_i) - 1);
      FULL_CODE:
        if (interleave_i) illegal_d = 1'b1;
        else begin
          mask_d = '1;
          full_d = 1'b1;
        end
      default: illegal_d = 1'b1;
    endcase
  end

  logic [COL_W-1:0] seq_col, int_col;
  assign seq_col = (base_q & ~mask_q) | ((base_q + beat_q) & mask_q);
  assign int_col = base_q ^ (beat_q & mask_q);

  assign col_o     = inter_q ? int_col : seq_col;
  assign active_o  = active_q;
  assign last_o    = active_q & ~full_q & (beat_q == mask_q);
  assign done_o    = done_q;
  assign illegal_o = illegal_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q    <= '0;
      beat_q    <= '0;
      mask_q    <= '0;
      full_q    <= 1'b0;
      inter_q   <= 1'b0;
      active_q  <= 1'b0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else if (start_i) begin
      base_q    <= col_start_i;
      beat_q    <= '0;
      mask_q    <= mask_d;
      full_q    <= full_d;
      inter_q   <= interleave_i;
      active_q  <= 1'b1;
      done_q    <= 1'b0;
      illegal_q <= illegal_d;
    end else if (active_q) begin
      if (term_i || last_o) begin
        active_q <= 1'b0;
        done_q   <= 1'b1;
      end else begin
        beat_q <= beat_q + 1'b1;
        done_q <= 1'b0;
      end
    end else begin
      done_q <= 1'b0;
    end
  end

endmodule

// File: rtl/sdram_burst_colseq_chk.sv
module sdram_burst_colseq_chk #(
  parameter int COL_W = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             term_i,
  input logic [COL_W-1:0] col_start_i,
  input logic [2:0]       blen_code_i,
  input logic             interleave_i,
  input logic [COL_W-1:0] col_o,
  input logic             active_o,
  input logic             last_o,
  input logic             done_o,
  input logic             illegal_o
);

  // R3
  start_col_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (active_o && col_o == $past(col_start_i)));

  // R7
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && last_o && !start_i) |=> (!active_o && done_o));

  // R8
  term_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_o && term_i && !start_i) |=> (!active_o && done_o));

  // R9
  replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> !done_o);

  // R10
  illegal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && interleave_i && blen_code_i == 3'd7) |=> (illegal_o && last_o));

  // R11
  idle_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active_o && !start_i) |=> (!active_o && !done_o));

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !active_o);

endmodule

bind sdram_burst_colseq sdram_burst_colseq_chk #(.COL_W(COL_W)) i_chk (.*);

// File: tb/test_sdram_burst_colseq.sv
module test_sdram_burst_colseq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start_i = 1'b0;
  logic       term_i = 1'b0;
  logic [8:0] col_start_i = '0;
  logic [2:0] blen_code_i = '0;
  logic       interleave_i = 1'b0;
  logic [8:0] col_o;
  logic       active_o, last_o, done_o, illegal_o;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sdram_burst_colseq i_sdram_burst_colseq (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_col(int base, int beat, int lg, bit full, bit inter);
    int m;
    if (full) return (base + beat) % 512;
    m = (1 << lg) - 1;
    if (inter) return base ^ (beat & m);
    return (base & ~m) | ((base + beat) & m);
  endfunction

  task automatic start_burst(input int col, input int code, input bit inter);
    @(negedge clk);
    start_i = 1'b1; col_start_i = 9'(col); blen_code_i = 3'(code); interleave_i = inter;
    @(negedge clk);
    start_i = 1'b0;
  endtask

  task automatic finite_burst(input string req, input int col, input int code,
                              input bit inter, input int lg, input bit ill);
    int n;
    n = 1 << lg;
    start_burst(col, code, inter);
    for (int b = 0; b < n; b++) begin
      chk(col_o == 9'(exp_col(col, b, lg, 1'b0, inter)), req, "col", col_o,
          exp_col(col, b, lg, 1'b0, inter));
      chk(active_o && last_o == (b == n - 1), req, "last", last_o, b == n - 1);
      chk(illegal_o == ill, "R10", "illegal", illegal_o, ill);
      if (b < n - 1) @(negedge clk);
    end
    @(negedge clk);
    chk(!active_o && done_o, "R7", "end done", done_o, 1);
    @(negedge clk);
    chk(!done_o, "R7", "done width", done_o, 0);
  endtask

  task automatic t_reset;
    chk(!active_o && !last_o && !done_o && !illegal_o && col_o == 0, "R1",
        "reset", {active_o, last_o, done_o, illegal_o}, 0);
  endtask

  task automatic t_full_page;
    start_burst(508, 7, 1'b0);
    for (int b = 0; b < 6; b++) begin
      chk(col_o == 9'(exp_col(508, b, 9, 1'b1, 1'b0)), "R6", "col", col_o,
          exp_col(508, b, 9, 1'b1, 1'b0));
      chk(active_o && !last_o, "R6", "no last", last_o, 0);
      if (b < 5) @(negedge clk);
    end
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    chk(!active_o && done_o, "R8", "term done", done_o, 1);
    @(negedge clk);
    chk(!done_o && !active_o, "R8", "after term", done_o, 0);
  endtask

  task automatic t_restart;
    start_burst(10, 3, 1'b0);
    chk(col_o == 10, "R3", "beat0", col_o, 10);
    @(negedge clk);
    chk(col_o == 11, "R4", "beat1", col_o, 11);
    start_i = 1'b1; term_i = 1'b1; col_start_i = 9'd101; blen_code_i = 3'd1; interleave_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0; term_i = 1'b0;
    chk(active_o && !done_o && col_o == 101, "R9", "replace col", col_o, 101);
    chk(!last_o, "R9", "replace last", last_o, 0);
    @(negedge clk);
    chk(col_o == 100 && last_o, "R9", "replace beat1", col_o, 100);
    @(negedge clk);
    chk(!active_o && done_o, "R9", "replace done", done_o, 1);
  endtask

  task automatic t_idle_term;
    @(negedge clk);
    term_i = 1'b1;
    @(negedge clk);
    term_i = 1'b0;
    chk(!active_o && !done_o, "R11", "idle term", done_o, 0);
  endtask

  initial begin
    #4 t_reset();
    #1 rst_n = 1'b1;
    finite_burst("R2", 77, 0, 1'b0, 0, 1'b0);
    finite_burst("R4", 13, 2, 1'b0, 2, 1'b0);
    finite_burst("R4", 5, 3, 1'b0, 3, 1'b0);
    finite_burst("R5", 13, 3, 1'b1, 3, 1'b0);
    finite_burst("R5", 6, 1, 1'b1, 1, 1'b0);
    finite_burst("R10", 37, 7, 1'b1, 0, 1'b1);
    finite_burst("R2", 200, 5, 1'b0, 0, 1'b1);
    finite_burst("R10", 40, 1, 1'b0, 1, 1'b0);
    t_full_page();
    t_restart();
    t_idle_term();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule